// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block paces every write and erase of an on-chip flash array. It counts pulses of a slow timing-generator clock, which reaches the block as a one-cycle enable `tg_tick` in the system clock domain. A bus-side agent issues one command with an address and data word. The block keeps `busy` high while the operation runs. At the end of each timed interval it fires an abstract program or erase strobe towards a behavioural memory model. When the whole operation is over it pulses `done` for one cycle.

Four operations exist. A single word program takes one fixed interval. A block program writes consecutive words inside one 64-byte row: the first word has its own interval and each later word a shorter one, with `wait_data` raised between words while the block waits for the next word. A closing end-sequence interval finishes the block. A segment erase clears one segment, and a mass erase clears the whole array. The highest information segment holds calibration data, so it is locked from reset. Any program or segment erase aimed at it is refused with a violation pulse until an explicit unlock.

The controller moves through these states: `ST_IDLE`, `ST_PROG`, `ST_BLK_FIRST`, `ST_BLK_WAIT`, `ST_BLK_NEXT`, `ST_BLK_END`, `ST_ERASE_SEG`, `ST_ERASE_ALL` and `ST_FINISH`.
- An accepted command goes from `ST_IDLE` or `ST_FINISH` to the state for its operation.
- Expiry of `ST_PROG`, `ST_ERASE_SEG`, `ST_ERASE_ALL` or `ST_BLK_END` leads to `ST_FINISH`.
- Expiry of `ST_BLK_FIRST` or `ST_BLK_NEXT` leads to `ST_BLK_END` on the last word of the row, and to `ST_BLK_WAIT` otherwise.
- From `ST_BLK_WAIT`, a data word leads to `ST_BLK_NEXT`, and expiry of the wait window leads to `ST_BLK_END`.
- `ST_FINISH` returns to `ST_IDLE` unless it accepts a new command.

Top module: `flash_timing_seq`

## Requirements
- R1: After reset, `busy`, `wait_data`, `done`, `access_viol`, `cmd_reject` and all memory strobes are low, and segment A (byte addresses 0x10C0 to 0x10FF) is locked.
- R2: A command with `cmd_op` = 0 programs one word. `busy` stays high for exactly 30 timing ticks, whatever the spacing of the ticks. `mem_prog` fires with the command address and data in the cycle of the 30th tick. `done` is high for one cycle right after `busy` falls.
- R3: A command with `cmd_op` = 1 starts a block. The first word, taken from `cmd_data`, is written after 25 ticks, and `wait_data` is then raised unless that word ends its row.
- R4: Each word accepted with `data_valid` during `wait_data` is written to the next word address (+2 bytes) after 18 ticks.
- R5: A block never crosses its 64-byte row. After the word at row offset 0x3E, the block goes straight to a 6-tick end sequence with no `wait_data`, and it then completes.
- R6: If no word arrives within 4 ticks of `wait_data` rising, the block ends with the 6-tick end sequence.
- R7: A command with `cmd_op` = 2 erases one segment in 4819 ticks. `mem_erase_seg` carries the segment base in `mem_addr`: 64-byte aligned inside 0x1000 to 0x10FF, and 512-byte aligned elsewhere.
- R8: A command with `cmd_op` = 3 erases everything in 10593 ticks. `mem_erase_incl_a` is high at the strobe only while segment A is unlocked.
- R9: While segment A is locked, a program, block or segment erase whose address falls in segment A pulses `access_viol` for one cycle. No `busy` and no strobe follow.
- R10: A pulse on `seg_a_unlock` lifts the lock, and a pulse on `seg_a_relock` restores it.
- R11: A command presented while `busy` is high is not started. `cmd_reject` pulses for one cycle, and the running operation finishes unchanged.
- R12: `data_valid` outside `wait_data` has no effect on the data written or on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tg_tick | input | 1 | One-cycle pulse per timing-generator period |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation: 0 program, 1 block, 2 segment erase, 3 mass erase |
| cmd_addr | input | AW | Byte address of the command |
| cmd_data | input | DW | Word for a program, or the first word of a block |
| data_valid | input | 1 | Next block word present |
| data_in | input | DW | Next block word |
| seg_a_unlock | input | 1 | Pulse that lifts the segment A lock |
| seg_a_relock | input | 1 | Pulse that restores the segment A lock |
| busy | output | 1 | Operation in progress |
| wait_data | output | 1 | Block is waiting for its next word |
| done | output | 1 | One-cycle completion pulse |
| access_viol | output | 1 | One-cycle pulse: locked segment A targeted |
| cmd_reject | output | 1 | One-cycle pulse: command arrived while busy |
| mem_prog | output | 1 | Program strobe to the array |
| mem_erase_seg | output | 1 | Segment erase strobe |
| mem_erase_all | output | 1 | Mass erase strobe |
| mem_erase_incl_a | output | 1 | Mass erase also clears segment A |
| mem_addr | output | AW | Program address or segment base |
| mem_data | output | DW | Word to program |

## Verification
The bench builds the block with its default counts (30, 25, 18, 6, 4819 and 10593 ticks), 16-bit words and a 4-tick data window. These keep the true erase durations inside the run. With 64-byte rows, a block started near the end of a row reaches the row boundary in two words, and one started mid-row reaches the wait timeout. Placing four 64-byte information segments at 0x1000 puts segment A at 0x10C0, right beside segment B, so the edge of the lock decode can be probed directly.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_BLOCK      = 2'd1,
        OP_SEG_ERASE  = 2'd2,
        OP_MASS_ERASE = 2'd3
    } fop_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_BLK_FIRST,
        ST_BLK_WAIT,
        ST_BLK_NEXT,
        ST_BLK_END,
        ST_ERASE_SEG,
        ST_ERASE_ALL,
        ST_FINISH
    } fst_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fseq_addr_map.sv
// Region decode: segment base of a command address, segment A hit, row end.
module fseq_addr_map #(
    parameter int unsigned AW             = 16,
    parameter int unsigned INFO_BASE      = 32'h1000,
    parameter int unsigned INFO_SEG_BYTES = 64,
    parameter int unsigned INFO_SEGS      = 4,
    parameter int unsigned MAIN_SEG_BYTES = 512,
    parameter int unsigned ROW_BYTES      = 64,
    parameter int unsigned WORD_BYTES     = 2
) (
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] seg_base,
    output logic          in_seg_a,
    output logic          row_last
);
    localparam logic [AW-1:0] INFO_LO   = AW'(INFO_BASE);
    localparam logic [AW-1:0] INFO_HI   = AW'(INFO_BASE + INFO_SEGS*INFO_SEG_BYTES - 1);
    localparam logic [AW-1:0] SEGA_LO   = AW'(INFO_BASE + (INFO_SEGS-1)*INFO_SEG_BYTES);
    localparam logic [AW-1:0] INFO_MASK = ~AW'(INFO_SEG_BYTES - 1);
    localparam logic [AW-1:0] MAIN_MASK = ~AW'(MAIN_SEG_BYTES - 1);

    logic in_info;

    always_comb begin
        in_info  = (cmd_addr >= INFO_LO) && (cmd_addr <= INFO_HI);
        in_seg_a = (cmd_addr >= SEGA_LO) && (cmd_addr <= INFO_HI);
        seg_base = in_info ? (cmd_addr & INFO_MASK) : (cmd_addr & MAIN_MASK);
    end

    generate
        if (ROW_BYTES <= WORD_BYTES) begin : g_row_single
            assign row_last = 1'b1;
        end else begin : g_row_multi
            localparam logic [AW-1:0] ROW_MASK = AW'(ROW_BYTES - 1);
            localparam logic [AW-1:0] ROW_TOP  = AW'(ROW_BYTES - WORD_BYTES);
            assign row_last = (cur_addr & ROW_MASK) >= ROW_TOP;
        end
    endgenerate

endmodule

// File: rtl/fseq_tick_timer.sv
// Down-counter paced by the timing-generator tick; expires on the tick seen at zero.
module fseq_tick_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && tick && (cnt_q == '0);

endmodule

// File: rtl/fseq_lock.sv
// Calibration segment lock: set by reset, cleared by unlock, set again by relock.
module fseq_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock,
    input  logic relock,
    output logic locked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (relock) begin
            locked <= 1'b1;
        end else if (unlock) begin
            locked <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_timing_seq.sv
module flash_timing_seq
    import flash_seq_pkg::*;
#(
    parameter int unsigned AW               = 16,
    parameter int unsigned DW               = 16,
    parameter int unsigned PROG_TICKS       = 30,
    parameter int unsigned BLK_FIRST_TICKS  = 25,
    parameter int unsigned BLK_NEXT_TICKS   = 18,
    parameter int unsigned BLK_END_TICKS    = 6,
    parameter int unsigned DATA_WAIT_TICKS  = 4,
    parameter int unsigned SEG_ERASE_TICKS  = 4819,
    parameter int unsigned MASS_ERASE_TICKS = 10593,
    parameter int unsigned ROW_BYTES        = 64,
    parameter int unsigned MAIN_SEG_BYTES   = 512,
    parameter int unsigned INFO_SEG_BYTES   = 64,
    parameter int unsigned INFO_SEGS        = 4,
    parameter int unsigned INFO_BASE        = 32'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tg_tick,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          data_valid,
    input  logic [DW-1:0] data_in,
    input  logic          seg_a_unlock,
    input  logic          seg_a_relock,
    output logic          busy,
    output logic          wait_data,
    output logic          done,
    output logic          access_viol,
    output logic          cmd_reject,
    output logic          mem_prog,
    output logic          mem_erase_seg,
    output logic          mem_erase_all,
    output logic          mem_erase_incl_a,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    localparam int unsigned WORD_BYTES = DW / 8;
    localparam int unsigned MAX_TICKS  = max2(max2(max2(PROG_TICKS, BLK_FIRST_TICKS),
                                                   max2(BLK_NEXT_TICKS, BLK_END_TICKS)),
                                              max2(max2(SEG_ERASE_TICKS, MASS_ERASE_TICKS),
                                                   DATA_WAIT_TICKS));
    localparam int unsigned CNT_W      = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;

    localparam logic [CNT_W-1:0] LD_PROG  = CNT_W'(PROG_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_FIRST = CNT_W'(BLK_FIRST_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_NEXT  = CNT_W'(BLK_NEXT_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_END   = CNT_W'(BLK_END_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_WAIT  = CNT_W'(DATA_WAIT_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_SEG   = CNT_W'(SEG_ERASE_TICKS - 1);
    localparam logic [CNT_W-1:0] LD_MASS  = CNT_W'(MASS_ERASE_TICKS - 1);
    localparam logic [AW-1:0]    WALIGN   = ~AW'(WORD_BYTES - 1);
    localparam logic [AW-1:0]    STEP     = AW'(WORD_BYTES);

    fst_e             state_q, state_d;
    logic [AW-1:0]    addr_q, addr_d;
    logic [DW-1:0]    data_q, data_d;
    logic             tmr_load, tmr_run, tmr_expire;
    logic [CNT_W-1:0] tmr_val;
    logic             locked_a;
    logic [AW-1:0]    cmd_seg_base;
    logic             cmd_in_a, row_last;
    logic             can_accept, cmd_blocked, cmd_go;
    logic             viol_q, rej_q;
    fop_e             op;

    assign op          = fop_e'(cmd_op);
    assign can_accept  = (state_q == ST_IDLE) || (state_q == ST_FINISH);
    assign cmd_blocked = locked_a && cmd_in_a && (op != OP_MASS_ERASE);
    assign cmd_go      = cmd_valid && can_accept && !cmd_blocked;
    assign tmr_run     = (state_q != ST_IDLE) && (state_q != ST_FINISH);

    fseq_addr_map #(
        .AW(AW), .INFO_BASE(INFO_BASE), .INFO_SEG_BYTES(INFO_SEG_BYTES),
        .INFO_SEGS(INFO_SEGS), .MAIN_SEG_BYTES(MAIN_SEG_BYTES),
        .ROW_BYTES(ROW_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_map (
        .cmd_addr (cmd_addr),
        .cur_addr (addr_q),
        .seg_base (cmd_seg_base),
        .in_seg_a (cmd_in_a),
        .row_last (row_last)
    );

    fseq_tick_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .tick     (tg_tick),
        .expire   (tmr_expire)
    );

    fseq_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .unlock (seg_a_unlock),
        .relock (seg_a_relock),
        .locked (locked_a)
    );

    // Next-state and interval selection
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        data_d   = data_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                state_d = ST_IDLE;
                if (cmd_go) begin
                    tmr_load = 1'b1;
                    addr_d   = cmd_addr & WALIGN;
                    data_d   = cmd_data;
                    unique case (op)
                        OP_PROG: begin
                            state_d = ST_PROG;
                            tmr_val = LD_PROG;
                        end
                        OP_BLOCK: begin
                            state_d = ST_BLK_FIRST;
                            tmr_val = LD_FIRST;
                        end
                        OP_SEG_ERASE: begin
                            state_d = ST_ERASE_SEG;
                            tmr_val = LD_SEG;
                            addr_d  = cmd_seg_base;
                        end
                        OP_MASS_ERASE: begin
                            state_d = ST_ERASE_ALL;
                            tmr_val = LD_MASS;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PROG, ST_ERASE_SEG, ST_ERASE_ALL, ST_BLK_END: begin
                if (tmr_expire) begin
                    state_d = ST_FINISH;
                end
            end
            ST_BLK_FIRST, ST_BLK_NEXT: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    if (row_last) begin
                        state_d = ST_BLK_END;
                        tmr_val = LD_END;
                    end else begin
                        state_d = ST_BLK_WAIT;
                        tmr_val = LD_WAIT;
                    end
                end
            end
            ST_BLK_WAIT: begin
                if (data_valid) begin
                    state_d  = ST_BLK_NEXT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_NEXT;
                    addr_d   = addr_q + STEP;
                    data_d   = data_in;
                end else if (tmr_expire) begin
                    state_d  = ST_BLK_END;
                    tmr_load = 1'b1;
                    tmr_val  = LD_END;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            rej_q  <= 1'b0;
        end else begin
            viol_q <= cmd_valid && can_accept && cmd_blocked;
            rej_q  <= cmd_valid && !can_accept;
        end
    end

    always_comb begin
        busy             = tmr_run;
        wait_data        = (state_q == ST_BLK_WAIT);
        done             = (state_q == ST_FINISH);
        access_viol      = viol_q;
        cmd_reject       = rej_q;
        mem_prog         = tmr_expire && ((state_q == ST_PROG) || (state_q == ST_BLK_FIRST) ||
                                          (state_q == ST_BLK_NEXT));
        mem_erase_seg    = tmr_expire && (state_q == ST_ERASE_SEG);
        mem_erase_all    = tmr_expire && (state_q == ST_ERASE_ALL);
        mem_erase_incl_a = !locked_a;
        mem_addr         = addr_q;
        mem_data         = data_q;
    end

endmodule

// File: rtl/flash_timing_seq_chk.sv
module flash_timing_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tg_tick,
    input logic data_valid,
    input logic busy,
    input logic wait_data,
    input logic done,
    input logic access_viol,
    input logic cmd_reject,
    input logic mem_prog,
    input logic mem_erase_seg,
    input logic mem_erase_all
);
    // R3
    wait_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_data |-> busy);

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_prog, mem_erase_seg, mem_erase_all}));

    // R2
    strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_prog || mem_erase_seg || mem_erase_all) |-> (busy && tg_tick));

    // R8
    erase_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_erase_seg || mem_erase_all) |=> done);

    // R9
    viol_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_viol |-> (!busy && !wait_data && !done));

    // R11
    reject_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $past(busy));

    // R6
    wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_data && !data_valid && !tg_tick) |=> wait_data);
endmodule

bind flash_timing_seq flash_timing_seq_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tg_tick       (tg_tick),
    .data_valid    (data_valid),
    .busy          (busy),
    .wait_data     (wait_data),
    .done          (done),
    .access_viol   (access_viol),
    .cmd_reject    (cmd_reject),
    .mem_prog      (mem_prog),
    .mem_erase_seg (mem_erase_seg),
    .mem_erase_all (mem_erase_all)
);

// File: tb/test_flash_timing_seq.sv
`timescale 1ns/1ps
module test_flash_timing_seq;

    localparam int T_PROG  = 30;
    localparam int T_FIRST = 25;
    localparam int T_NEXT  = 18;
    localparam int T_END   = 6;
    localparam int T_WAIT  = 4;
    localparam int T_SEG   = 4819;
    localparam int T_MASS  = 10593;

    localparam logic [1:0] OPC_PROG = 2'd0;
    localparam logic [1:0] OPC_BLK  = 2'd1;
    localparam logic [1:0] OPC_SEG  = 2'd2;
    localparam logic [1:0] OPC_MASS = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  feed;
        logic [15:0] ticks;
        logic [7:0]  progs;
        logic        viol;
        logic [15:0] exp_addr;
        logic [15:0] exp_data;
        logic [7:0]  waits;
    } vec_t;

    // Fed block words are 16'hD000 + index.
    localparam vec_t VECS [11] = '{
        // R2 single word
        '{OPC_PROG, 16'h8000, 16'hA5A5, 8'd0, 16'(T_PROG), 8'd1, 1'b0, 16'h8000, 16'hA5A5, 8'd0},
        // R5 two words to the row end, leftover words not taken
        '{OPC_BLK, 16'h803C, 16'h2222, 8'd5, 16'(T_FIRST + 1 + T_NEXT + T_END), 8'd2, 1'b0,
          16'h803E, 16'hD000, 8'd1},
        // R4 R6 three words then timeout
        '{OPC_BLK, 16'h8000, 16'h3333, 8'd2,
          16'(T_FIRST + 1 + T_NEXT + 1 + T_NEXT + T_WAIT + T_END), 8'd3, 1'b0,
          16'h8004, 16'hD001, 8'(2 + T_WAIT)},
        // R6 no further word at all
        '{OPC_BLK, 16'h8010, 16'h1111, 8'd0, 16'(T_FIRST + T_WAIT + T_END), 8'd1, 1'b0,
          16'h8010, 16'h1111, 8'(T_WAIT)},
        // R7 main segment
        '{OPC_SEG, 16'h8345, 16'h0000, 8'd0, 16'(T_SEG), 8'd0, 1'b0, 16'h8200, 16'h0000, 8'd0},
        // R7 information segment
        '{OPC_SEG, 16'h1085, 16'h0000, 8'd0, 16'(T_SEG), 8'd0, 1'b0, 16'h1080, 16'h0000, 8'd0},
        // R9 R1 locked segment A
        '{OPC_SEG, 16'h10C4, 16'h0000, 8'd0, 16'd0, 8'd0, 1'b1, 16'h0000, 16'h0000, 8'd0},
        '{OPC_PROG, 16'h10FE, 16'h7777, 8'd0, 16'd0, 8'd0, 1'b1, 16'h0000, 16'h0000, 8'd0},
        '{OPC_BLK, 16'h10C0, 16'h7777, 8'd0, 16'd0, 8'd0, 1'b1, 16'h0000, 16'h0000, 8'd0},
        // R8 mass erase while locked
        '{OPC_MASS, 16'h0000, 16'h0000, 8'd0, 16'(T_MASS), 8'd0, 1'b0, 16'h0000, 16'h0000, 8'd0},
        // R9 last word of segment B is not locked
        '{OPC_PROG, 16'h10BE, 16'h5A5A, 8'd0, 16'(T_PROG), 8'd1, 1'b0, 16'h10BE, 16'h5A5A, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tg_tick = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        data_valid = 1'b0;
    logic [15:0] data_in = '0;
    logic        seg_a_unlock = 1'b0;
    logic        seg_a_relock = 1'b0;
    logic        busy, wait_data, done, access_viol, cmd_reject;
    logic        mem_prog, mem_erase_seg, mem_erase_all, mem_erase_incl_a;
    logic [15:0] mem_addr, mem_data;

    int tick_div = 1;
    int checks = 0;
    int fails = 0;
    bit wd_hit = 1'b0;

    int          r_ticks, r_cycles, r_progs, r_segs, r_alls, r_viol, r_rej, r_done, r_waits;
    logic [15:0] r_last_addr, r_last_data, r_seg_addr;
    logic        r_incl;

    always #2.5 clk = ~clk;

    flash_timing_seq #(
        .AW(16), .DW(16), .PROG_TICKS(T_PROG), .BLK_FIRST_TICKS(T_FIRST),
        .BLK_NEXT_TICKS(T_NEXT), .BLK_END_TICKS(T_END), .DATA_WAIT_TICKS(T_WAIT),
        .SEG_ERASE_TICKS(T_SEG), .MASS_ERASE_TICKS(T_MASS)
    ) i_flash_timing_seq (
        .clk, .rst_n, .tg_tick, .cmd_valid, .cmd_op, .cmd_addr, .cmd_data,
        .data_valid, .data_in, .seg_a_unlock, .seg_a_relock,
        .busy, .wait_data, .done, .access_viol, .cmd_reject,
        .mem_prog, .mem_erase_seg, .mem_erase_all, .mem_erase_incl_a,
        .mem_addr, .mem_data
    );

    // Timing-generator pulse, updated just after each rising edge
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk);
            #1;
            if (tick_div <= 1) begin
                tg_tick = 1'b1;
            end else begin
                ph = (ph + 1) % tick_div;
                tg_tick = (ph == 0);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] op, input logic viol);
        if (viol) return "R9";
        case (op)
            OPC_PROG: return "R2";
            OPC_BLK:  return "R3";
            OPC_SEG:  return "R7";
            default:  return "R8";
        endcase
    endfunction

    task automatic pulse_lock(input bit unlock);
        @(negedge clk);
        if (unlock) seg_a_unlock = 1'b1; else seg_a_relock = 1'b1;
        @(negedge clk);
        seg_a_unlock = 1'b0;
        seg_a_relock = 1'b0;
    endtask

    // Issue one command and watch it to completion.
    task automatic run_cmd(input logic [1:0] op, input logic [15:0] addr, input logic [15:0] data,
                           input int feed, input int inj, input bit noise);
        int n, fed;
        bit stop;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        r_ticks = 0; r_cycles = 0; r_progs = 0; r_segs = 0; r_alls = 0; r_viol = 0;
        r_rej = 0; r_done = 0; r_waits = 0; r_incl = 1'b0;
        r_last_addr = '0; r_last_data = '0; r_seg_addr = '0;
        n = 0; fed = 0; stop = 1'b0;
        while (!stop) begin
            if (busy) begin
                r_cycles++;
                if (tg_tick) r_ticks++;
            end
            if (wait_data) r_waits++;
            if (mem_prog) begin
                r_progs++; r_last_addr = mem_addr; r_last_data = mem_data;
            end
            if (mem_erase_seg) begin
                r_segs++; r_seg_addr = mem_addr;
            end
            if (mem_erase_all) begin
                r_alls++; r_incl = mem_erase_incl_a;
            end
            if (access_viol) r_viol++;
            if (cmd_reject) r_rej++;
            if (done) r_done++;
            if (wait_data && fed < feed) begin
                data_valid = 1'b1; data_in = 16'hD000 + 16'(fed); fed++;
            end else if (noise && busy) begin
                data_valid = 1'b1; data_in = 16'hFFFF;
            end else begin
                data_valid = 1'b0;
            end
            if (n == inj) begin
                cmd_valid = 1'b1; cmd_op = OPC_SEG; cmd_addr = 16'h8000;
            end else begin
                cmd_valid = 1'b0;
            end
            n++;
            if (done || !busy || n > 40000) stop = 1'b1;
            @(negedge clk);
        end
        data_valid = 1'b0;
        cmd_valid = 1'b0;
    endtask

    task automatic run_all;
        // R1 reset state
        @(negedge clk);
        chk(!busy && !wait_data && !done, "R1", "busy/wait/done after reset",
            {busy, wait_data, done}, 0);
        chk(!access_viol && !cmd_reject, "R1", "flags after reset", {access_viol, cmd_reject}, 0);
        chk(!mem_prog && !mem_erase_seg && !mem_erase_all, "R1", "strobes after reset",
            {mem_prog, mem_erase_seg, mem_erase_all}, 0);

        // Vector table
        for (int i = 0; i < 11; i++) begin
            run_cmd(VECS[i].op, VECS[i].addr, VECS[i].data, int'(VECS[i].feed), -1, 1'b0);
            chk(r_ticks == int'(VECS[i].ticks), req_of(VECS[i].op, VECS[i].viol), "busy ticks",
                r_ticks, VECS[i].ticks);
            chk(r_viol == int'(VECS[i].viol), "R9", "violation pulse", r_viol, VECS[i].viol);
            chk(r_done == int'(!VECS[i].viol), "R2", "done pulse", r_done, !VECS[i].viol);
            if (VECS[i].viol) begin
                chk(r_progs + r_segs + r_alls == 0, "R9", "strobes on refusal",
                    r_progs + r_segs + r_alls, 0);
            end else if (VECS[i].op == OPC_PROG || VECS[i].op == OPC_BLK) begin
                chk(r_progs == int'(VECS[i].progs), "R5", "program strobes", r_progs,
                    VECS[i].progs);
                chk(r_last_addr == VECS[i].exp_addr, "R4", "last program address",
                    r_last_addr, VECS[i].exp_addr);
                chk(r_last_data == VECS[i].exp_data, "R4", "last program data",
                    r_last_data, VECS[i].exp_data);
                chk(r_waits == int'(VECS[i].waits), "R6", "wait_data cycles", r_waits,
                    VECS[i].waits);
            end else if (VECS[i].op == OPC_SEG) begin
                chk(r_segs == 1 && r_seg_addr == VECS[i].exp_addr, "R7", "segment base",
                    r_seg_addr, VECS[i].exp_addr);
            end else begin
                chk(r_alls == 1 && r_incl == 1'b0, "R8", "mass erase spares locked A",
                    {r_alls[7:0], 7'd0, r_incl}, 16'h0100);
            end
        end

        // R12 data_valid while programming has no effect
        run_cmd(OPC_PROG, 16'h8200, 16'h1234, 0, -1, 1'b1);
        chk(r_last_data == 16'h1234, "R12", "data under noise", r_last_data, 16'h1234);
        chk(r_ticks == T_PROG && r_progs == 1, "R12", "ticks under noise", r_ticks, T_PROG);

        // R11 command while busy
        run_cmd(OPC_PROG, 16'h8300, 16'h4321, 0, 5, 1'b0);
        chk(r_rej == 1, "R11", "reject pulses", r_rej, 1);
        chk(r_segs == 0 && r_ticks == T_PROG && r_last_data == 16'h4321, "R11",
            "running program unchanged", r_ticks, T_PROG);

        // R2 sparse ticks: count ticks, not cycles
        tick_div = 3;
        run_cmd(OPC_PROG, 16'h8400, 16'h0F0F, 0, -1, 1'b0);
        chk(r_ticks == T_PROG, "R2", "ticks with divided pacing", r_ticks, T_PROG);
        chk(r_cycles >= 3 * T_PROG - 2 && r_cycles <= 3 * T_PROG, "R2", "cycles with divided pacing",
            r_cycles, 3 * T_PROG);
        tick_div = 1;
        repeat (4) @(negedge clk);

        // R10 unlock, then act on segment A
        pulse_lock(1'b1);
        run_cmd(OPC_PROG, 16'h10C2, 16'hCAFE, 0, -1, 1'b0);
        chk(r_viol == 0 && r_progs == 1 && r_last_addr == 16'h10C2, "R10", "program A unlocked",
            r_last_addr, 16'h10C2);
        run_cmd(OPC_SEG, 16'h10C0, 16'h0000, 0, -1, 1'b0);
        chk(r_segs == 1 && r_seg_addr == 16'h10C0, "R10", "erase A unlocked", r_seg_addr, 16'h10C0);
        run_cmd(OPC_MASS, 16'h0000, 16'h0000, 0, -1, 1'b0);
        chk(r_alls == 1 && r_incl == 1'b1, "R8", "mass erase includes unlocked A", r_incl, 1);
        pulse_lock(1'b0);
        run_cmd(OPC_PROG, 16'h10C2, 16'hBEEF, 0, -1, 1'b0);
        chk(r_viol == 1 && r_progs == 0 && r_ticks == 0, "R10", "relock refuses A", r_viol, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual expired expected finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule